// File: doc/BRIEF.md
# Program Counter with Conditional Branch Redirect

This block keeps the fetch address of a 32-bit core. It holds the current program counter (PC) in a register and works out the next fetch address on every cycle. In sequential flow it moves on by one instruction word (four bytes). When the instruction now being executed is a conditional branch and its comparison holds, it moves to the branch target instead.

The core's decode and operand-read logic present three things to the block: a 3-bit branch-kind code for the current instruction, the two source operand values and the sign-extended branch immediate. The block compares the operands, signed or unsigned as the code asks. In the same cycle it drives the taken flag and the target address, and the next rising clock edge loads the chosen address into the PC. Jumps, exceptions and the instruction memory belong to other parts of the core.

Top module: `pc_branch_unit`

## Requirements
- R1: Reset is synchronous and active low. On a rising clock edge with `rst_n` low, `pc_q` becomes 0, whatever the branch inputs are.
- R2: On a rising edge with `rst_n` high and `taken` low, `pc_q` advances by 4.
- R3: `target` is `pc_q + imm` with bits [1:0] forced to zero. It is combinational from the current `pc_q` and `imm`.
- R4: On a rising edge with `rst_n` high and `taken` high, `pc_q` loads the value `target` had before that edge.
- R5: Branch kind 1 (equal) is taken when `opa == opb`. Kind 2 (not equal) is taken when `opa != opb`.
- R6: Kind 3 (less than) is taken when `opa < opb` as two's-complement numbers. Kind 4 (greater or equal) is taken when `opa >= opb` as two's-complement numbers.
- R7: Kind 5 (less than) is taken when `opa < opb` as unsigned magnitudes. Kind 6 (greater or equal) is taken when `opa >= opb` as unsigned magnitudes.
- R8: Kind 0 (not a branch) and the unused kind 7 hold `taken` low for any operand values, so the PC advances by 4.
- R9: Bits [1:0] of `pc_q` are zero at all times after reset.
- R10: `taken` is combinational. It reflects the current `br_kind`, `opa` and `opb` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_kind | input | 3 | Branch kind of the current instruction (0 none, 1 eq, 2 ne, 3 lt, 4 ge, 5 ltu, 6 geu, 7 none) |
| opa | input | 32 | First source operand value |
| opb | input | 32 | Second source operand value |
| imm | input | 32 | Sign-extended branch byte offset |
| pc_q | output | 32 | Current program counter |
| target | output | 32 | Branch target address, word aligned |
| taken | output | 1 | Branch resolved as taken this cycle |

## Verification
`taken` and `target` carry no register, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these two outputs one nanosecond later. The effect on `pc_q` is due one rising edge later. The bench therefore waits for that edge and reads `pc_q` on the following falling edge, before it drives the next vector. A reset asserted together with a taken branch is checked the same way: after one edge `pc_q` must read zero.

// File: rtl/pcb_pkg.sv
// Package: shared types for the program-counter block.
// Assumes a 3-bit branch-kind code produced by the instruction decoder.
package pcb_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE = 3'd0,
        BK_EQ   = 3'd1,
        BK_NE   = 3'd2,
        BK_LT   = 3'd3,
        BK_GE   = 3'd4,
        BK_LTU  = 3'd5,
        BK_GEU  = 3'd6,
        BK_RSVD = 3'd7
    } br_kind_e;
endpackage

// File: rtl/pcb_cond.sv
// Branch condition evaluator.
// Decides from the branch kind and two operands whether a branch is taken.
// SHARED_SUB=1 derives equality, unsigned and signed less-than from a single
// XLEN+1 bit subtraction; SHARED_SUB=0 uses separate comparators.
// Assumes operands are stable for the whole cycle; output is purely combinational.
module pcb_cond
    import pcb_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic              taken_o
);
    localparam int MSB = XLEN - 1;

    logic is_eq;
    logic is_ltu;
    logic is_lts;

    generate
        if (SHARED_SUB) begin : g_shared
            logic [XLEN:0] diff;
            // One subtractor: borrow gives unsigned order, zero result gives equality.
            always_comb begin
                diff   = {1'b0, a_i} - {1'b0, b_i};
                is_eq  = (diff[MSB:0] == '0);
                is_ltu = diff[XLEN];
                is_lts = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff[XLEN];
            end
        end else begin : g_split
            // Independent comparators for each relation.
            always_comb begin
                is_eq  = (a_i == b_i);
                is_ltu = (a_i < b_i);
                is_lts = ($signed(a_i) < $signed(b_i));
            end
        end
    endgenerate

    // Select the relation that the branch kind asks for.
    always_comb begin
        unique case (br_kind_e'(kind_i))
            BK_EQ:   taken_o = is_eq;
            BK_NE:   taken_o = !is_eq;
            BK_LT:   taken_o = is_lts;
            BK_GE:   taken_o = !is_lts;
            BK_LTU:  taken_o = is_ltu;
            BK_GEU:  taken_o = !is_ltu;
            default: taken_o = 1'b0;
        endcase
    end

    // Non-branch kinds never redirect the PC.
    always_comb begin
        if (kind_i == BK_NONE || kind_i == BK_RSVD)
            assert_none_quiet_R8: assert (!taken_o);
    end

    // Equal operands are never strictly less than each other.
    always_comb begin
        if (a_i == b_i && (kind_i == BK_LT || kind_i == BK_LTU))
            assert_equal_not_less_R6: assert (!taken_o);
    end
endmodule

// File: rtl/pcb_target.sv
// Address arithmetic: sequential successor and word-aligned branch target.
// Assumes instructions are XLEN bits wide and the PC addresses bytes.
module pcb_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] tgt_o
);
    localparam int              INSTR_BYTES = XLEN / 8;
    localparam logic [XLEN-1:0] STEP        = XLEN'(INSTR_BYTES);
    localparam logic [XLEN-1:0] LOW_MASK    = XLEN'(INSTR_BYTES - 1);

    // Form both candidate next addresses.
    always_comb begin
        seq_o = pc_i + STEP;
        tgt_o = (pc_i + imm_i) & ~LOW_MASK;
    end

    // The target always lands on an instruction boundary.
    always_comb begin
        assert_target_aligned_R3: assert ((tgt_o & LOW_MASK) == '0);
    end
endmodule

// File: rtl/pcb_reg.sv
// PC state register with synchronous active-low reset to zero.
// Assumes next_i is already chosen between sequential and branch addresses.
module pcb_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] next_i,
    output logic [XLEN-1:0] pc_o
);
    // Hold the fetch address; clear it when reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_o <= '0;
        else        pc_o <= next_i;
    end

    // A reset edge always leaves the PC at zero.
    assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> pc_o == '0);

    // After reset the PC stays word aligned.
    assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);
endmodule

// File: rtl/pc_branch_unit.sv
// Program counter with conditional branch redirect.
// Combines the condition evaluator, address arithmetic and the PC register.
// Assumes br_kind, opa, opb and imm describe the instruction at pc_q.
module pc_branch_unit
    import pcb_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit SHARED_SUB = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] br_kind,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [XLEN-1:0]   imm,
    output logic [XLEN-1:0]   pc_q,
    output logic [XLEN-1:0]   target,
    output logic              taken
);
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] next_pc;

    pcb_cond #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cond (
        .kind_i  (br_kind),
        .a_i     (opa),
        .b_i     (opb),
        .taken_o (taken)
    );

    pcb_target #(.XLEN(XLEN)) u_target (
        .pc_i  (pc_q),
        .imm_i (imm),
        .seq_o (seq_addr),
        .tgt_o (target)
    );

    // Choose the redirect target or the sequential successor.
    always_comb begin
        next_pc = taken ? target : seq_addr;
    end

    pcb_reg #(.XLEN(XLEN)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (next_pc),
        .pc_o   (pc_q)
    );

    // Sequential flow advances by one instruction word.
    assert_step_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> pc_q == $past(pc_q) + XLEN'(4));

    // A taken branch lands on the target seen before the edge.
    assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> pc_q == $past(target));
endmodule

// File: tb/test_pc_branch_unit.sv
`timescale 1ns/1ps
module test_pc_branch_unit;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  br_kind = 3'd0;
    logic [31:0] opa = '0, opb = '0, imm = '0;
    logic [31:0] pc_q, target;
    logic        taken;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] pc_exp;

    always #2.5 clk = ~clk;

    pc_branch_unit i_pc_branch_unit (
        .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .opa(opa), .opb(opb),
        .imm(imm), .pc_q(pc_q), .target(target), .taken(taken)
    );

    // Vectors: kind, opa, opb, imm, expected taken
    localparam logic [2:0]  V_K [NV] = '{3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd4, 3'd5,
                                         3'd5, 3'd6, 3'd6, 3'd0, 3'd7, 3'd3, 3'd4, 3'd1, 3'd6};
    localparam logic [31:0] V_A [NV] = '{32'd5, 32'd5, 32'd5, 32'd7, 32'hFFFF_FFFF, 32'd1,
                                         32'd1, 32'h8000_0000, 32'd1, 32'hFFFF_FFFF,
                                         32'hFFFF_FFFF, 32'd3, 32'd5, 32'd5, 32'd4, 32'd4,
                                         32'd0, 32'd2};
    localparam logic [31:0] V_B [NV] = '{32'd5, 32'd6, 32'd6, 32'd7, 32'd1, 32'hFFFF_FFFF,
                                         32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd1,
                                         32'd1, 32'd3, 32'd5, 32'd5, 32'd4, 32'd4, 32'd0,
                                         32'd9};
    localparam logic [31:0] V_I [NV] = '{32'd16, 32'd16, -32'sd8, 32'd8, 32'd12, 32'd12,
                                         -32'sd4, 32'd20, 32'd24, 32'd24, -32'sd12, 32'd4,
                                         32'd100, 32'd100, 32'd8, -32'sd16, 32'd6, 32'd40};
    localparam logic        V_T [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                         1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd1, 3'd2: return "R5";
            3'd3, 3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default:    return "R8";
        endcase
    endfunction

    // Drive one instruction at the falling edge, check comb outputs, then the next PC.
    task automatic step(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] i, input logic exp_t);
        logic [31:0] tgt_exp;
        br_kind = k; opa = a; opb = b; imm = i;
        #1;
        tgt_exp = (pc_exp + i) & 32'hFFFF_FFFC;
        chk({kind_tag(k), " taken, same-cycle R10"}, {31'd0, taken}, {31'd0, exp_t});
        chk("R3 target", target, tgt_exp);
        pc_exp = exp_t ? tgt_exp : pc_exp + 32'd4;
        @(negedge clk);
        chk(exp_t ? "R4 redirect" : "R2 sequential", pc_q, pc_exp);
        chk("R9 alignment", {30'd0, pc_q[1:0]}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 reset state", pc_q, 32'd0);
        rst_n = 1'b1;
        pc_exp = '0;
        for (int s = 0; s < 3; s++) step(3'd0, 32'd1, 32'd1, 32'd64, 1'b0);
        for (int v = 0; v < NV; v++) step(V_K[v], V_A[v], V_B[v], V_I[v], V_T[v]);
        // Kind 7 with operands that would satisfy any relation: still no redirect (R8).
        step(3'd7, 32'd0, 32'd0, 32'd256, 1'b0);
        // Reset asserted while a branch is taken: reset wins (R1).
        br_kind = 3'd1; opa = 32'd9; opb = 32'd9; imm = 32'd64; rst_n = 1'b0;
        #1;
        chk("R10 taken during reset", {31'd0, taken}, 32'd1);
        @(negedge clk);
        chk("R1 reset over branch", pc_q, 32'd0);
        rst_n = 1'b1; pc_exp = '0;
        step(3'd2, 32'd9, 32'd9, 32'd64, 1'b0);
        step(3'd5, 32'd0, 32'd1, -32'sd8, 1'b1);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule